// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is a serial-peripheral slave that sits in front of a byte-wide memory array held in on-chip registers. A host drives chip select, serial clock and serial data in. The block decodes an opcode in the first byte of each frame. It then reads bytes out with automatic address advance, collects a page of write data, reports a status byte, or sets and clears a write-enable latch. Serial clock modes 0 and 3 are both accepted. Data in is taken on the rising serial clock edge and data out changes on the falling edge, most significant bit first in both directions.

The serial pins are brought into a fast system clock through synchronizers, and every serial edge is detected in that domain. A write is collected in a page buffer and committed only when chip select rises in the short window after the last bit of a byte. It is then copied into the array while a busy counter runs for a parameterised number of system clocks. A companion unit supplies a single inhibit signal that vetoes a commit. A hold input pauses a frame at any bit and lets it resume at the same bit.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Frames use opcodes 0x06 (set enable), 0x04 (clear enable), 0x03 (read), 0x02 (write) and 0x05 (status read), shifted in MSB first on rising serial clock edges. Any other opcode is ignored.
- R2: The enable latch is set by 0x06 and cleared by 0x04 on the rising edge of clock 7, counting clocks from 0. Chip select rising before that edge leaves the latch unchanged.
- R3: The status frame returns the byte {6'b0, enable, busy} (bit 1 = enable, bit 0 = busy), MSB first. The first bit comes on the falling edge of clock 7, and the byte repeats for as long as clocking continues.
- R4: Read and write carry a 16-bit address after the opcode. Bits above ADDR_W-1 are ignored. Read data starts on the falling edge of clock 23, the address advances after each byte, and the address wraps from the top of the array to 0.
- R5: A write is committed only if the enable latch is set and chip select rises after bit 0 of a data byte has been sampled and before the next rising serial clock edge. Rising at any other time cancels the write and leaves the enable latch as it was.
- R6: During a write, only the low PAGE_W address bits advance after each byte. Bytes past the end of the page wrap to its start and overwrite earlier bytes of the same frame.
- R7: A commit clears the enable latch and holds busy for WRITE_CYCLES system clocks. While busy is set, only the status frame is served: enable commands are ignored and a read drives no output.
- R8: When the inhibit input is high as chip select rises, the write is cancelled and nothing changes.
- R9: Hold starts when hold_n falls while the serial clock is low and ends when hold_n rises while the serial clock is low. While held, the serial clock and data in are ignored, the output enable is low, and the frame resumes at the same bit.
- R10: If chip select rises during hold, the frame is aborted and a pending write is not committed.
- R11: After reset the enable and busy bits are 0 and every array byte reads 0xFF. The output enable is low whenever chip select is high.
- R12: If chip select falls while the serial clock is high (mode 3), that edge samples nothing, and bit 0 is taken on the next rising serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold request, active low |
| wr_inhibit | input | 1 | Veto on write commit from the protection unit |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_en | output | 1 | Output enable for the serial data out pad driver |

## Verification
Two functions can land in the same system cycle. The first pair is chip select rising while hold is active, which must abort the frame and not commit the write that is otherwise ready. The bench provokes this by completing a full data byte, asserting hold, and raising chip select before release. It then judges the result by reading status (busy still 0, enable still 1) and by reading back the untouched byte. The second pair is a new frame opening while the committed page is still being copied into the array. Status and read frames are issued straight after a commit. The bench checks that the read drives no output, that status shows busy, and that the complete page reads back intact once busy drops.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WREN,
    OP_WRDI,
    OP_READ,
    OP_WRITE,
    OP_RDSR
  } op_e;

  localparam logic [7:0] CODE_SET_EN = 8'h06;
  localparam logic [7:0] CODE_CLR_EN = 8'h04;
  localparam logic [7:0] CODE_READ   = 8'h03;
  localparam logic [7:0] CODE_WRITE  = 8'h02;
  localparam logic [7:0] CODE_STAT   = 8'h05;

  // R1: opcode byte to command; unknown codes map to no command
  function automatic op_e op_decode(input logic [7:0] code);
    case (code)
      CODE_SET_EN: return OP_WREN;
      CODE_CLR_EN: return OP_WRDI;
      CODE_READ:   return OP_READ;
      CODE_WRITE:  return OP_WRITE;
      CODE_STAT:   return OP_RDSR;
      default:     return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [7:0]        rdata,
  output logic              rvalid
);

  localparam int PSIZE = 1 << PAGE_W;

  logic [7:0]       pg_mem [PSIZE];
  logic [PSIZE-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) pg_mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[widx] <= 1'b1;
  end

  assign rdata  = pg_mem[ridx];
  assign rvalid = vld[ridx];

endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int CYCLES = 500000,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [PAGE_W-1:0] cp_idx,
  output logic              cp_en
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      tick <= '0;
    end else if (busy) begin
      if (tick == CW'(CYCLES - 1)) busy <= 1'b0;
      tick <= tick + 1'b1;
    end
  end

  assign cp_idx = tick[PAGE_W-1:0];
  assign cp_en  = busy && (tick < CW'(1 << PAGE_W));

  // R7
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    busy && (tick != CW'(CYCLES - 1)) |=> busy);

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6,
  parameter int WRITE_CYCLES = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_sdi,
  input  logic spi_hold_n,
  input  logic wr_inhibit,
  output logic spi_sdo,
  output logic spi_sdo_en
);
  import spi_ee_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SW = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;

  // synchronized pins: {hold_n, sdi, sck, csn}
  logic [3:0] syn_q;
  logic csn_s, sck_s, si_s, hold_s;
  logic csn_p, sck_p, hold_p;

  spi_ee_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_hold_n, spi_sdi, spi_sck, spi_csn}),
    .q(syn_q)
  );

  assign {hold_s, si_s, sck_s, csn_s} = syn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_p <= 1'b1; sck_p <= 1'b0; hold_p <= 1'b1;
    end else begin
      csn_p <= csn_s; sck_p <= sck_s; hold_p <= hold_s;
    end
  end

  logic csn_fall, csn_rise, sck_rise, sck_fall, hold_fall, hold_rise, act;
  assign csn_fall  = csn_p && !csn_s;
  assign csn_rise  = !csn_p && csn_s;
  assign sck_rise  = !sck_p && sck_s;
  assign sck_fall  = sck_p && !sck_s;
  assign hold_fall = hold_p && !hold_s;
  assign hold_rise = !hold_p && hold_s;
  assign act       = !csn_s;

  // frame state
  logic [5:0]        cnt;
  logic [SW-1:0]     shreg;
  op_e               op;
  logic              wen, held, have_byte;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-PAGE_W-1:0] wr_base;
  logic [PAGE_W-1:0] wr_off;
  logic              sdo_q, oe_q;
  logic [7:0]        rdata;

  // write timer and page buffer
  logic              busy, cp_en, pb_valid, mem_we, commit;
  logic [PAGE_W-1:0] cp_idx;
  logic [7:0]        pb_data;

  logic              sck_in, pb_we, out_phase;
  logic [7:0]        in_byte, status, out_src;
  logic [ADDR_W-1:0] addr_in;
  logic [5:0]        cnt_nx;
  op_e               op_dec, op_acc;

  assign sck_in   = act && !held && sck_rise;
  assign in_byte  = {shreg[6:0], si_s};
  assign addr_in  = {shreg[ADDR_W-2:0], si_s};
  assign op_dec   = op_decode(in_byte);
  assign op_acc   = (busy && op_dec != OP_RDSR) ? OP_NONE : op_dec;
  assign status   = {6'b0, wen, busy};
  assign out_src  = (op == OP_RDSR) ? status : rdata;
  assign out_phase = ((op == OP_READ) && (cnt >= 6'd24)) ||
                     ((op == OP_RDSR) && (cnt >= 6'd8));
  assign pb_we    = sck_in && (op == OP_WRITE) && (cnt == 6'd31);

  always_comb begin
    if ((op == OP_RDSR) && (cnt == 6'd15)) cnt_nx = 6'd8;
    else if (cnt == 6'd31)                 cnt_nx = 6'd24;
    else                                   cnt_nx = cnt + 6'd1;
  end

  assign commit = csn_rise && (op == OP_WRITE) && have_byte && (cnt == 6'd24) &&
                  !held && wen && !wr_inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; shreg <= '0; op <= OP_NONE; wen <= 1'b0; held <= 1'b0;
      rd_ptr <= '0; wr_base <= '0; wr_off <= '0; have_byte <= 1'b0;
      sdo_q <= 1'b0; oe_q <= 1'b0;
    end else if (csn_fall) begin
      cnt <= '0; op <= OP_NONE; have_byte <= 1'b0; held <= 1'b0; oe_q <= 1'b0;
    end else if (csn_rise) begin
      op <= OP_NONE; oe_q <= 1'b0; held <= 1'b0;
      if (commit) wen <= 1'b0;
    end else if (act) begin
      if (hold_fall && !sck_s)              held <= 1'b1;
      else if (hold_rise && !sck_s && held) held <= 1'b0;
      if (sck_in) begin
        shreg <= {shreg[SW-2:0], si_s};
        cnt   <= cnt_nx;
        if (cnt == 6'd7) begin
          op <= op_acc;
          if (op_acc == OP_WREN) wen <= 1'b1;
          if (op_acc == OP_WRDI) wen <= 1'b0;
        end
        if (op == OP_READ) begin
          if (cnt == 6'd23)      rd_ptr <= addr_in;
          else if (cnt == 6'd31) rd_ptr <= rd_ptr + 1'b1;
        end
        if (op == OP_WRITE) begin
          if (cnt == 6'd23) begin
            wr_base <= addr_in[ADDR_W-1:PAGE_W];
            wr_off  <= addr_in[PAGE_W-1:0];
          end else if (cnt == 6'd31) begin
            wr_off    <= wr_off + 1'b1;
            have_byte <= 1'b1;
          end
        end
      end
      if (sck_fall && !held && out_phase) begin
        oe_q  <= 1'b1;
        sdo_q <= out_src[~cnt[2:0]];
      end
    end
  end

  spi_ee_pagebuf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst(rst), .clr(csn_fall && !busy),
    .we(pb_we), .widx(wr_off), .wdata(in_byte),
    .ridx(cp_idx), .rdata(pb_data), .rvalid(pb_valid)
  );

  spi_ee_wtimer #(.CYCLES(WRITE_CYCLES), .PAGE_W(PAGE_W)) u_wtim (
    .clk(clk), .rst(rst), .start(commit),
    .busy(busy), .cp_idx(cp_idx), .cp_en(cp_en)
  );

  // memory array, block-RAM style: one write port, one registered read port
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  assign mem_we = cp_en && pb_valid;

  always_ff @(posedge clk) begin
    if (mem_we) mem[{wr_base, cp_idx}] <= pb_data;
    rdata <= mem[rd_ptr];
  end

  assign spi_sdo    = sdo_q;
  assign spi_sdo_en = oe_q && !held;

  // R5
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(csn_rise));
  // R7
  busy_wen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wen);
  // R7
  mem_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    held && sck_rise && !csn_fall && !csn_rise |=> $stable(cnt));
  // R10
  hold_abort_chk: assert property (@(posedge clk) disable iff (rst)
    csn_rise && held |=> !$rose(busy));
  // R11
  so_off_chk: assert property (@(posedge clk) disable iff (rst)
    csn_rise |=> !spi_sdo_en);
  // R2
  wen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sck_rise && !csn_rise |=> $stable(wen));

endmodule

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb;

  localparam int H = 6;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, inh = 1'b0;
  logic sdo, sdo_en;
  logic cpol = 1'b0;
  int total = 0, bad = 0;
  logic done = 1'b0;

  logic [7:0] wbuf [80];
  logic [7:0] rbuf [80];
  logic byte_en_all, byte_en_any, rd_en_all, rd_en_any;

  always #5 clk = ~clk;

  spi_eeprom_ctrl #(.ADDR_W(AW), .PAGE_W(6), .WRITE_CYCLES(1500)) u_dut (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_sdi(sdi),
    .spi_hold_n(hold_n), .wr_inhibit(inh), .spi_sdo(sdo), .spi_sdo_en(sdo_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    @(negedge clk); sck = 1'b0; sdi = b;
    repeat (H) @(negedge clk);
    r = sdo;
    byte_en_all &= sdo_en; byte_en_any |= sdo_en;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    if (!cpol) sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    byte_en_all = 1'b1; byte_en_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bitx(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic fstart();
    @(negedge clk); sck = cpol;
    repeat (H) @(negedge clk);
    csn = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic fstop();
    repeat (2) @(negedge clk);
    csn = 1'b1;
    repeat (2*H) @(negedge clk);
    hold_n = 1'b1; sck = cpol;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] c);
    logic [7:0] d;
    fstart(); xfer(c, d); fstop();
  endtask

  task automatic rdsr(output logic [7:0] s1, output logic [7:0] s2);
    logic [7:0] d;
    fstart(); xfer(8'h05, d); xfer(8'h00, s1); xfer(8'h00, s2); fstop();
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] d;
    fstart(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    fstop();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] d;
    fstart(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    rd_en_all = 1'b1; rd_en_any = 1'b0;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, rbuf[i]);
      rd_en_all &= byte_en_all; rd_en_any |= byte_en_any;
    end
    fstop();
  endtask

  task automatic wait_idle();
    logic [7:0] s1, s2;
    for (int k = 0; k < 40; k++) begin
      rdsr(s1, s2);
      if (!s1[0]) break;
    end
  endtask

  initial begin
    #(1200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s1, s2, d, acc;
    logic r;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 idle oe", sdo_en, 0);
    rdsr(s1, s2);
    chk("R11 status after reset", s1, 8'h00);
    rd(16'h0000, 1);
    chk("R11 array init", rbuf[0], 8'hFF);
    chk("R4 output enabled in data", rd_en_all, 1);

    // R2 / R3 enable latch and status
    cmd(8'h06);
    rdsr(s1, s2);
    chk("R2 set enable", s1, 8'h02);
    chk("R3 status repeats", s2, 8'h02);
    cmd(8'h04);
    rdsr(s1, s2);
    chk("R2 clear enable", s1, 8'h00);
    fstart();
    for (int i = 7; i >= 2; i--) bitx(((8'h06 >> i) & 1) != 0, r);
    fstop();
    rdsr(s1, s2);
    chk("R2 short frame cancels", s1, 8'h00);
    cmd(8'h9C);
    rdsr(s1, s2);
    chk("R1 unknown opcode ignored", s1, 8'h00);

    // R5 / R7 byte write, busy behaviour
    cmd(8'h06);
    wbuf[0] = 8'hA5;
    wr(16'h0005, 1);
    rdsr(s1, s2);
    chk("R7 busy and enable cleared", s1, 8'h01);
    cmd(8'h06);
    rd(16'h0005, 1);
    chk("R7 read refused while busy", rd_en_any, 0);
    wait_idle();
    rdsr(s1, s2);
    chk("R7 enable ignored while busy", s1, 8'h00);
    rd(16'h0005, 1);
    chk("R5 committed byte", rbuf[0], 8'hA5);

    // R5 no enable -> no write
    wbuf[0] = 8'h3C;
    wr(16'h0006, 1);
    rdsr(s1, s2);
    chk("R5 no enable not busy", s1, 8'h00);
    rd(16'h0006, 1);
    chk("R5 no enable no write", rbuf[0], 8'hFF);

    // R5 chip select rises mid byte
    cmd(8'h06);
    fstart(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h06, d); xfer(8'h11, d);
    for (int i = 0; i < 4; i++) bitx(1'b1, r);
    fstop();
    rdsr(s1, s2);
    chk("R5 cancel keeps enable", s1, 8'h02);
    rd(16'h0006, 1);
    chk("R5 cancelled write", rbuf[0], 8'hFF);

    // R6 page wrap, R4 read crosses page
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr(16'h007E, 4);
    wait_idle();
    rd(16'h007E, 4);
    chk("R4 seq b0", rbuf[0], 8'h11);
    chk("R4 seq b1", rbuf[1], 8'h22);
    chk("R4 read crosses page", rbuf[2], 8'hFF);
    rd(16'h0040, 2);
    chk("R6 wrap b2", rbuf[0], 8'h33);
    chk("R6 wrap b3", rbuf[1], 8'h44);

    // R6 overwrite sweep: 66 bytes into page at 0x100
    cmd(8'h06);
    for (int i = 0; i < 66; i++) wbuf[i] = 8'(i) ^ 8'h5A;
    wr(16'h0100, 66);
    wait_idle();
    rd(16'h0100, 64);
    for (int i = 0; i < 64; i++) begin
      int last;
      last = (i < 2) ? i + 64 : i;
      chk("R6 page sweep", rbuf[i], 8'(last) ^ 8'h5A);
    end

    // R4 wrap at top and ignored upper address bits
    cmd(8'h06);
    wbuf[0] = 8'hC3;
    wr(16'h03FF, 1);
    wait_idle();
    rd(16'hFFFF, 2);
    chk("R4 top byte", rbuf[0], 8'hC3);
    chk("R4 wrap to zero", rbuf[1], 8'hFF);
    rd(16'hFC05, 1);
    chk("R4 upper bits ignored", rbuf[0], 8'hA5);

    // R8 inhibit
    inh = 1'b1;
    cmd(8'h06);
    wbuf[0] = 8'h77;
    wr(16'h0010, 1);
    rdsr(s1, s2);
    chk("R8 inhibit no busy", s1, 8'h02);
    inh = 1'b0;
    rd(16'h0010, 1);
    chk("R8 inhibit no write", rbuf[0], 8'hFF);
    cmd(8'h04);

    // R9 hold in address and in data phase
    fstart(); xfer(8'h03, d); xfer(8'h00, d);
    for (int i = 7; i >= 3; i--) bitx(((8'h7E >> i) & 1) != 0, r);
    @(negedge clk); hold_n = 1'b0;
    repeat (2*H) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sdi = 1'b1; sck = 1'b1; repeat (H) @(negedge clk);
      sck = 1'b0; repeat (H) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (2*H) @(negedge clk);
    for (int i = 2; i >= 0; i--) bitx(((8'h7E >> i) & 1) != 0, r);
    acc = '0;
    for (int i = 7; i >= 5; i--) begin bitx(1'b0, r); acc[i] = r; end
    @(negedge clk); hold_n = 1'b0;
    repeat (2*H) @(negedge clk);
    chk("R9 output off in hold", sdo_en, 0);
    for (int k = 0; k < 3; k++) begin
      sdi = 1'b0; sck = 1'b1; repeat (H) @(negedge clk);
      sck = 1'b0; repeat (H) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (2*H) @(negedge clk);
    for (int i = 4; i >= 0; i--) begin bitx(1'b0, r); acc[i] = r; end
    chk("R9 resumed byte", acc, 8'h11);
    xfer(8'h00, d);
    chk("R9 next byte", d, 8'h22);
    fstop();

    // R10 chip select rises during hold
    cmd(8'h06);
    fstart(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h20, d); xfer(8'h99, d);
    @(negedge clk); hold_n = 1'b0;
    repeat (2*H) @(negedge clk);
    fstop();
    rdsr(s1, s2);
    chk("R10 abort no busy", s1, 8'h02);
    rd(16'h0020, 1);
    chk("R10 abort no write", rbuf[0], 8'hFF);
    cmd(8'h04);

    // R12 mode 3
    cpol = 1'b1;
    @(negedge clk); sck = 1'b1;
    repeat (2*H) @(negedge clk);
    cmd(8'h06);
    wbuf[0] = 8'h5E;
    wr(16'h0030, 1);
    wait_idle();
    rd(16'h0030, 1);
    chk("R12 mode3 write/read", rbuf[0], 8'h5E);
    rdsr(s1, s2);
    chk("R12 mode3 status", s1, 8'h00);
    cpol = 1'b0;
    @(negedge clk); sck = 1'b0;
    repeat (2*H) @(negedge clk);
    chk("R11 oe low after frames", sdo_en, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule